// File: doc/BRIEF.md
# I2C Multi-Payload Command Sequencer

This block runs one I2C command made of an ordered list of payloads. Each payload is a descriptor: a 7-bit target address, a direction flag, a byte length, and an offset into a small on-chip data buffer. Once `cmd_go` is pulsed, the sequencer turns the list into primitive operations for a separate bit-level bus engine. The four operations are start condition, stop condition, byte write and byte read. The sequencer builds each address byte, picks the acknowledge value sent after each byte it reads, and decides where stop conditions go. When the command ends it raises one done pulse with one pass/fail bit.

The payloads of a command are chained with repeated starts. Only the last payload, or a payload that has just failed, ends with a stop condition. A failure ends the whole command at once.

Bytes to transmit are taken from the data buffer. Bytes received are stored back into the same buffer. The host reaches the buffer through a simple write/read port. All bus timing belongs to the engine, which answers each request with a done pulse, a success flag and, for reads, a data byte.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: Payloads are run in list order (descriptor index 0 first). Each payload opens with a start request (op code 0). Between payloads of one command no stop request (op code 1) is issued, so each following start acts as a repeated start.
- R2: The first byte written in a payload (op code 2) is the 7-bit address in bits 7:1, with bit 0 set to 1 for a read payload and 0 for a write payload.
- R3: In a write payload, the data bytes are written in order from buffer locations offset, offset+1, and so on, after the address byte. An unsuccessful address or data write fails the payload.
- R4: In a read payload, each byte is fetched with a read request (op code 3) and stored at buffer locations offset, offset+1, and so on. `eng_nack` is 0 on every read request except the last one of the payload, where it is 1.
- R5: After the last payload, or after any failed step, a stop request is issued. If the stop itself is unsuccessful, the command fails.
- R6: A failed step causes the stop request to be the very next request. The remaining payloads are skipped and `cmd_ok` reads 0 with `cmd_done`.
- R7: If a start request is unsuccessful, no address or data byte is requested for that payload; the stop request follows directly.
- R8: A payload of length zero issues only its address byte. A command with a payload count of zero issues no engine request and reports `cmd_done` with `cmd_ok` = 1 one cycle after `cmd_go`.
- R9: `cmd_done` is a single-cycle pulse and `cmd_ok` is valid during it.
- R10: The host buffer read port returns data one cycle after the address is presented. Host buffer writes and `cmd_go` pulses are ignored while a command is running.
- R11: `eng_req` is a single-cycle pulse. No new request is made until the engine has answered the previous one with `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Write enable for the descriptor table |
| desc_idx | input | IDX_W | Descriptor slot to write |
| desc_addr | input | 7 | 7-bit target address |
| desc_rd | input | 1 | 1 = read payload, 0 = write payload |
| desc_len | input | LEN_W | Payload length in bytes |
| desc_ptr | input | BUF_AW | Buffer offset of the payload data |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | BUF_AW | Host buffer address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data (1-cycle latency) |
| cmd_go | input | 1 | Start a command |
| cmd_count | input | CNT_W | Number of payloads in the command |
| cmd_done | output | 1 | Command finished pulse |
| cmd_ok | output | 1 | Command result, valid with cmd_done |
| eng_req | output | 1 | Engine operation request pulse |
| eng_op | output | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to write |
| eng_nack | output | 1 | Acknowledge value for a read: 1 = NACK |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_ok | input | 1 | Operation succeeded (ACK seen for writes) |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
The bench keeps the default sizes: four descriptor slots, a 4-bit length and a 16-entry buffer. With these sizes one command can contain a write payload, a multi-byte read payload, a zero-length payload and a single-byte read payload. The reads stay clear of the write source bytes. A scripted engine model fails exactly one chosen operation per run. This places a failure on each kind of step in turn: a first start, an address byte, a data byte, a middle read, a later repeated start and the final stop. The expected request trace is rebuilt by the bench from the descriptors.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_STOP
  } st_e;

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction
endpackage

// File: rtl/seq_desc_table.sv
module seq_desc_table #(
  parameter int NPAY   = 4,
  parameter int LEN_W  = 4,
  parameter int BUF_AW = 4,
  localparam int IDX_W = (NPAY > 1) ? $clog2(NPAY) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [6:0]        wr_addr,
  input  logic              wr_rd,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [BUF_AW-1:0] wr_ptr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [6:0]        rd_addr,
  output logic              rd_rd,
  output logic [LEN_W-1:0]  rd_len,
  output logic [BUF_AW-1:0] rd_ptr
);
  logic [6:0]        t_addr [NPAY];
  logic              t_rd   [NPAY];
  logic [LEN_W-1:0]  t_len  [NPAY];
  logic [BUF_AW-1:0] t_ptr  [NPAY];

  for (genvar g = 0; g < NPAY; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        t_addr[g] <= '0;
        t_rd[g]   <= 1'b0;
        t_len[g]  <= '0;
        t_ptr[g]  <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        t_addr[g] <= wr_addr;
        t_rd[g]   <= wr_rd;
        t_len[g]  <= wr_len;
        t_ptr[g]  <= wr_ptr;
      end
    end
  end

  always_comb begin
    rd_addr = t_addr[rd_idx];
    rd_rd   = t_rd[rd_idx];
    rd_len  = t_len[rd_idx];
    rd_ptr  = t_ptr[rd_idx];
  end
endmodule

// File: rtl/seq_data_buf.sv
module seq_data_buf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = seq_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          busy,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          s_we,
  input  logic [AW-1:0] s_waddr,
  input  logic [DW-1:0] s_wdata,
  input  logic [AW-1:0] s_raddr,
  output logic [DW-1:0] s_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          w_en;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;

  always_comb begin
    w_en   = s_we || (h_we && !busy);
    w_addr = s_we ? s_waddr : h_addr;
    w_data = s_we ? s_wdata : h_wdata;
  end

  always_ff @(posedge clk) begin
    if (w_en) mem[w_addr] <= w_data;
  end

  always_ff @(posedge clk) begin
    h_rdata <= mem[h_addr];
    s_rdata <= mem[s_raddr];
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int NPAY   = 4,
  parameter int LEN_W  = 4,
  parameter int BUF_AW = 4,
  localparam int IDX_W = (NPAY > 1) ? $clog2(NPAY) : 1,
  localparam int CNT_W = $clog2(NPAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_done,
  output logic              cmd_ok,
  output logic [IDX_W-1:0]  d_idx,
  input  logic [6:0]        d_addr,
  input  logic              d_rd,
  input  logic [LEN_W-1:0]  d_len,
  input  logic [BUF_AW-1:0] d_ptr,
  output logic              busy,
  output logic [BUF_AW-1:0] m_raddr,
  input  logic [BYTE_W-1:0] m_rdata,
  output logic              m_we,
  output logic [BUF_AW-1:0] m_waddr,
  output logic [BYTE_W-1:0] m_wdata,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nack,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic [BYTE_W-1:0] eng_rdata
);
  st_e               state;
  logic              waiting;
  logic              fetched;
  logic              failed;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  count_q;
  logic [6:0]        cur_addr;
  logic              cur_rd;
  logic [LEN_W-1:0]  cur_len;
  logic [BUF_AW-1:0] cur_ptr;
  logic [LEN_W-1:0]  bcnt;
  logic              last_byte;
  logic              last_pay;

  always_comb begin
    d_idx     = idx;
    busy      = (state != ST_IDLE);
    m_raddr   = cur_ptr + BUF_AW'(bcnt);
    last_byte = (bcnt == cur_len - LEN_W'(1));
    last_pay  = (CNT_W'(idx) == count_q - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      waiting   <= 1'b0;
      fetched   <= 1'b0;
      failed    <= 1'b0;
      idx       <= '0;
      count_q   <= '0;
      cur_addr  <= '0;
      cur_rd    <= 1'b0;
      cur_len   <= '0;
      cur_ptr   <= '0;
      bcnt      <= '0;
      cmd_done  <= 1'b0;
      cmd_ok    <= 1'b0;
      m_we      <= 1'b0;
      m_waddr   <= '0;
      m_wdata   <= '0;
      eng_req   <= 1'b0;
      eng_op    <= OP_START;
      eng_wdata <= '0;
      eng_nack  <= 1'b0;
    end else begin
      eng_req  <= 1'b0;
      cmd_done <= 1'b0;
      m_we     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_go) begin
            count_q <= cmd_count;
            idx     <= '0;
            failed  <= 1'b0;
            waiting <= 1'b0;
            if (cmd_count == '0) begin
              cmd_done <= 1'b1;
              cmd_ok   <= 1'b1;
            end else begin
              state <= ST_START;
            end
          end
        end

        ST_START: begin
          if (!waiting) begin
            eng_req  <= 1'b1;
            eng_op   <= OP_START;
            eng_nack <= 1'b0;
            waiting  <= 1'b1;
            cur_addr <= d_addr;
            cur_rd   <= d_rd;
            cur_len  <= d_len;
            cur_ptr  <= d_ptr;
            bcnt     <= '0;
            fetched  <= 1'b0;
          end else if (eng_done) begin
            waiting <= 1'b0;
            if (eng_ok) begin
              state <= ST_ADDR;
            end else begin
              failed <= 1'b1;
              state  <= ST_STOP;
            end
          end
        end

        ST_ADDR: begin
          if (!waiting) begin
            eng_req   <= 1'b1;
            eng_op    <= OP_WRITE;
            eng_wdata <= addr_byte(cur_addr, cur_rd);
            eng_nack  <= 1'b0;
            waiting   <= 1'b1;
          end else if (eng_done) begin
            waiting <= 1'b0;
            if (!eng_ok) begin
              failed <= 1'b1;
              state  <= ST_STOP;
            end else if (cur_len != '0) begin
              state <= ST_DATA;
            end else if (last_pay) begin
              state <= ST_STOP;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_START;
            end
          end
        end

        ST_DATA: begin
          if (!waiting) begin
            if (cur_rd) begin
              eng_req  <= 1'b1;
              eng_op   <= OP_READ;
              eng_nack <= last_byte;
              waiting  <= 1'b1;
            end else if (!fetched) begin
              fetched <= 1'b1;
            end else begin
              eng_req   <= 1'b1;
              eng_op    <= OP_WRITE;
              eng_wdata <= m_rdata;
              eng_nack  <= 1'b0;
              waiting   <= 1'b1;
              fetched   <= 1'b0;
            end
          end else if (eng_done) begin
            waiting <= 1'b0;
            if (cur_rd) begin
              m_we    <= 1'b1;
              m_waddr <= m_raddr;
              m_wdata <= eng_rdata;
            end
            if (!eng_ok) begin
              failed <= 1'b1;
              state  <= ST_STOP;
            end else if (!last_byte) begin
              bcnt <= bcnt + LEN_W'(1);
            end else if (last_pay) begin
              state <= ST_STOP;
            end else begin
              idx   <= idx + IDX_W'(1);
              state <= ST_START;
            end
          end
        end

        ST_STOP: begin
          if (!waiting) begin
            eng_req  <= 1'b1;
            eng_op   <= OP_STOP;
            eng_nack <= 1'b0;
            waiting  <= 1'b1;
          end else if (eng_done) begin
            waiting  <= 1'b0;
            cmd_done <= 1'b1;
            cmd_ok   <= !failed && eng_ok;
            state    <= ST_IDLE;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer #(
  parameter int NPAY      = 4,
  parameter int LEN_W     = 4,
  parameter int BUF_DEPTH = 16,
  localparam int IDX_W    = (NPAY > 1) ? $clog2(NPAY) : 1,
  localparam int CNT_W    = $clog2(NPAY + 1),
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [IDX_W-1:0]  desc_idx,
  input  logic [6:0]        desc_addr,
  input  logic              desc_rd,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [BUF_AW-1:0] desc_ptr,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic [7:0]        buf_rdata,
  input  logic              cmd_go,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_done,
  output logic              cmd_ok,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wdata,
  output logic              eng_nack,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic [7:0]        eng_rdata
);
  logic [IDX_W-1:0]  d_idx;
  logic [6:0]        d_addr;
  logic              d_rd;
  logic [LEN_W-1:0]  d_len;
  logic [BUF_AW-1:0] d_ptr;
  logic              busy;
  logic [BUF_AW-1:0] m_raddr;
  logic [7:0]        m_rdata;
  logic              m_we;
  logic [BUF_AW-1:0] m_waddr;
  logic [7:0]        m_wdata;

  seq_desc_table #(.NPAY(NPAY), .LEN_W(LEN_W), .BUF_AW(BUF_AW)) i_desc (
    .clk(clk), .rst(rst),
    .wr_en(desc_we), .wr_idx(desc_idx), .wr_addr(desc_addr), .wr_rd(desc_rd),
    .wr_len(desc_len), .wr_ptr(desc_ptr),
    .rd_idx(d_idx), .rd_addr(d_addr), .rd_rd(d_rd), .rd_len(d_len), .rd_ptr(d_ptr)
  );

  seq_data_buf #(.DEPTH(BUF_DEPTH)) i_buf (
    .clk(clk), .busy(busy),
    .h_we(buf_we), .h_addr(buf_addr), .h_wdata(buf_wdata), .h_rdata(buf_rdata),
    .s_we(m_we), .s_waddr(m_waddr), .s_wdata(m_wdata),
    .s_raddr(m_raddr), .s_rdata(m_rdata)
  );

  seq_ctrl #(.NPAY(NPAY), .LEN_W(LEN_W), .BUF_AW(BUF_AW)) i_ctrl (
    .clk(clk), .rst(rst),
    .cmd_go(cmd_go), .cmd_count(cmd_count), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
    .d_idx(d_idx), .d_addr(d_addr), .d_rd(d_rd), .d_len(d_len), .d_ptr(d_ptr),
    .busy(busy),
    .m_raddr(m_raddr), .m_rdata(m_rdata), .m_we(m_we), .m_waddr(m_waddr), .m_wdata(m_wdata),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_go,
  input logic       cmd_done,
  input logic       cmd_ok,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic       eng_done,
  input logic       eng_ok
);
  logic       in_cmd;
  logic       go_acc;
  logic       need_start;
  logic       outstanding;
  logic       after_fail;
  logic       had_fail;
  logic       any_op;
  logic [1:0] last_op;

  assign go_acc = cmd_go && (!in_cmd || cmd_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cmd      <= 1'b0;
      need_start  <= 1'b0;
      outstanding <= 1'b0;
      after_fail  <= 1'b0;
      had_fail    <= 1'b0;
      any_op      <= 1'b0;
      last_op     <= 2'd0;
    end else begin
      if (go_acc) begin
        in_cmd     <= 1'b1;
        need_start <= 1'b1;
        had_fail   <= 1'b0;
        any_op     <= 1'b0;
      end else if (cmd_done) begin
        in_cmd <= 1'b0;
      end
      if (eng_req) begin
        outstanding <= 1'b1;
        need_start  <= 1'b0;
        after_fail  <= 1'b0;
        any_op      <= 1'b1;
        last_op     <= eng_op;
      end else if (eng_done) begin
        outstanding <= 1'b0;
        if (!eng_ok) begin
          had_fail <= 1'b1;
          if (last_op != seq_pkg::OP_STOP) after_fail <= 1'b1;
        end
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_req |=> !eng_req);                                                       // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> !outstanding);                                                   // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);                                                     // R9
  AST_FIRST_START: assert property (@(posedge clk) disable iff (rst)
    (eng_req && need_start) |-> (eng_op == seq_pkg::OP_START));                  // R1
  AST_FAIL_TO_STOP: assert property (@(posedge clk) disable iff (rst)
    (eng_req && after_fail) |-> (eng_op == seq_pkg::OP_STOP));                   // R6
  AST_END_STOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && any_op) |-> (last_op == seq_pkg::OP_STOP && !outstanding));     // R5
  AST_FAIL_RESULT: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && had_fail) |-> !cmd_ok);                                         // R6
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_cmd |-> !eng_req);                                                       // R10
endmodule

bind i2c_cmd_sequencer seq_checker i_seq_checker (
  .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_done(cmd_done), .cmd_ok(cmd_ok),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done), .eng_ok(eng_ok)
);

// File: tb/test_i2c_cmd_sequencer.sv
`timescale 1ns/1ps
module test_i2c_cmd_sequencer;
  localparam int NPAY = 4, LEN_W = 4, BUF_DEPTH = 16;
  localparam int IDX_W = 2, CNT_W = 3, BUF_AW = 4;
  localparam int LAT = 2;

  typedef struct packed {
    logic [2:0] cnt;
    logic [7:0] fail_at;
    logic [4:0] nops;
    logic       ok;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd4, 8'hFF, 5'd15, 1'b1},
    '{3'd1, 8'hFF, 5'd5,  1'b1},
    '{3'd4, 8'd0,  5'd2,  1'b0},
    '{3'd4, 8'd1,  5'd3,  1'b0},
    '{3'd4, 8'd3,  5'd5,  1'b0},
    '{3'd4, 8'd7,  5'd9,  1'b0},
    '{3'd4, 8'd14, 5'd15, 1'b0},
    '{3'd2, 8'hFF, 5'd10, 1'b1},
    '{3'd4, 8'd9,  5'd11, 1'b0},
    '{3'd3, 8'hFF, 5'd12, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic desc_we = 0;
  logic [IDX_W-1:0] desc_idx = '0;
  logic [6:0] desc_addr = '0;
  logic desc_rd = 0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [BUF_AW-1:0] desc_ptr = '0;
  logic buf_we = 0;
  logic [BUF_AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic cmd_go = 0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic cmd_done, cmd_ok;
  logic eng_req;
  logic [1:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_nack;
  logic eng_done = 0, eng_ok = 0;
  logic [7:0] eng_rdata = '0;

  always #10 clk = ~clk;

  i2c_cmd_sequencer #(.NPAY(NPAY), .LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH)) i_i2c_cmd_sequencer (.*);

  int n_chk = 0, n_fail = 0;
  int fail_at = 255;
  int nops = 0, done_cnt = 0, busy_cnt = 0, cur_num = 0;
  logic last_ok = 0;
  logic [1:0] log_op [32];
  logic [7:0] log_dat [32];
  logic       log_nack [32];
  logic [1:0] exp_op [32];
  logic [7:0] exp_dat [32];
  logic       exp_nack [32];
  int  exp_n;
  logic exp_ok;

  logic [6:0] T_ADDR [4] = '{7'h50, 7'h50, 7'h21, 7'h33};
  logic       T_RD   [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
  int         T_LEN  [4] = '{2, 3, 0, 1};
  int         T_PTR  [4] = '{0, 4, 8, 10};

  // Engine model: answers each request LAT cycles later, failing op number fail_at.
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (rst) begin
      busy_cnt = 0;
    end else if (eng_req) begin
      if (nops < 32) begin
        log_op[nops] = eng_op;
        log_dat[nops] = eng_wdata;
        log_nack[nops] = eng_nack;
      end
      cur_num = nops;
      nops++;
      busy_cnt = LAT;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        eng_done = 1'b1;
        eng_ok = (cur_num != fail_at);
        eng_rdata = 8'hC0 + 8'(cur_num);
      end
    end
    if (!rst && cmd_done) begin
      done_cnt++;
      last_ok = cmd_ok;
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic nk);
    exp_op[exp_n] = op; exp_dat[exp_n] = d; exp_nack[exp_n] = nk; exp_n++;
  endtask

  // Expected trace from the requirements (R1..R7).
  task automatic build_exp(input int cnt, input int fa);
    bit failed = 0;
    exp_n = 0;
    for (int p = 0; p < cnt && !failed; p++) begin
      push(2'd0, 8'h00, 1'b0);
      if (exp_n - 1 == fa) begin failed = 1; break; end
      push(2'd2, {T_ADDR[p], T_RD[p]}, 1'b0);
      if (exp_n - 1 == fa) begin failed = 1; break; end
      for (int b = 0; b < T_LEN[p]; b++) begin
        if (T_RD[p]) push(2'd3, 8'h00, b == T_LEN[p] - 1);
        else push(2'd2, 8'h10 + 8'(T_PTR[p] + b), 1'b0);
        if (exp_n - 1 == fa) begin failed = 1; break; end
      end
    end
    if (cnt > 0) push(2'd1, 8'h00, 1'b0);
    exp_ok = !failed && (exp_n - 1 != fa);
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_addr = BUF_AW'(a); buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask

  task automatic host_rd(input int a, output logic [7:0] d);
    @(negedge clk); buf_addr = BUF_AW'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic wait_done(input int prev);
    for (int i = 0; i < 3000 && done_cnt == prev; i++) @(negedge clk);
  endtask

  task automatic run_cmd(input int cnt, input int fa);
    int prev;
    fail_at = fa; nops = 0; prev = done_cnt;
    @(negedge clk); cmd_go = 1; cmd_count = CNT_W'(cnt);
    @(negedge clk); cmd_go = 0;
    wait_done(prev);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int prev, mism;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // Reset state (R9, R11)
    check(cmd_done == 0, "R9 reset cmd_done", cmd_done, 0);
    check(eng_req == 0, "R11 reset eng_req", eng_req, 0);
    check(cmd_ok == 0, "R9 reset cmd_ok", cmd_ok, 0);

    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      desc_we = 1; desc_idx = IDX_W'(p); desc_addr = T_ADDR[p]; desc_rd = T_RD[p];
      desc_len = LEN_W'(T_LEN[p]); desc_ptr = BUF_AW'(T_PTR[p]);
    end
    @(negedge clk); desc_we = 0;

    // Vector table: R1..R7
    for (int v = 0; v < NVEC; v++) begin
      for (int a = 0; a < BUF_DEPTH; a++) host_wr(a, 8'h10 + 8'(a));
      prev = done_cnt;
      run_cmd(int'(VECS[v].cnt), int'(VECS[v].fail_at));
      build_exp(int'(VECS[v].cnt), int'(VECS[v].fail_at));
      check(done_cnt == prev + 1, "R9 one done pulse", done_cnt - prev, 1);
      check(nops == int'(VECS[v].nops) && nops == exp_n, "R5/R6 request count", nops, exp_n);
      check(last_ok == VECS[v].ok && last_ok == exp_ok, "R6 cmd_ok", last_ok, exp_ok);
      mism = 0;
      for (int k = 0; k < exp_n && k < 32; k++) begin
        if (log_op[k] != exp_op[k]) mism++;
        else if (exp_op[k] == 2'd2 && exp_dat[k] != log_dat[k]) mism++;
        else if (exp_op[k] == 2'd3 && exp_nack[k] != log_nack[k]) mism++;
      end
      check(mism == 0, "R1 R2 R3 R4 R7 trace", mism, 0);
      if (v == 0) begin
        // R4: read bytes stored at the payload offset (ops 6,7,8,13)
        host_rd(4, rd);  check(rd == 8'hC6, "R4 stored byte 4", rd, 8'hC6);
        host_rd(5, rd);  check(rd == 8'hC7, "R4 stored byte 5", rd, 8'hC7);
        host_rd(6, rd);  check(rd == 8'hC8, "R4 stored byte 6", rd, 8'hC8);
        host_rd(7, rd);  check(rd == 8'h17, "R4 beyond length", rd, 8'h17);
        host_rd(10, rd); check(rd == 8'hCD, "R4 single read", rd, 8'hCD);
        // R8: zero-length payload 2 emits just its address 0x42
        check(log_op[9] == 2'd0 && log_op[10] == 2'd2 && log_dat[10] == 8'h42 && log_op[11] == 2'd0,
              "R8 zero length", log_dat[10], 8'h42);
      end
    end

    // R8: zero payload count
    prev = done_cnt; nops = 0;
    @(negedge clk); cmd_go = 1; cmd_count = '0;
    @(negedge clk); cmd_go = 0;
    check(cmd_done == 1 && cmd_ok == 1, "R8 empty command done", {cmd_done, cmd_ok}, 3);
    @(negedge clk);
    check(nops == 0 && done_cnt == prev + 1, "R8 empty command no request", nops, 0);

    // R10: host write and cmd_go ignored while busy
    host_wr(12, 8'h1C);
    prev = done_cnt; nops = 0; fail_at = 255;
    @(negedge clk); cmd_go = 1; cmd_count = 3'd1;
    @(negedge clk); cmd_go = 0;
    repeat (3) @(negedge clk);
    buf_we = 1; buf_addr = 4'd12; buf_wdata = 8'hEE; cmd_go = 1; cmd_count = 3'd4;
    @(negedge clk); buf_we = 0; cmd_go = 0;
    wait_done(prev);
    repeat (4) @(negedge clk);
    check(done_cnt == prev + 1 && nops == 5, "R10 go while busy ignored", nops, 5);
    host_rd(12, rd);
    check(rd == 8'h1C, "R10 host write while busy ignored", rd, 8'h1C);
    host_wr(12, 8'h5A);
    host_rd(12, rd);
    check(rd == 8'h5A, "R10 host write when idle", rd, 8'h5A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule